// File: doc/BRIEF.md
# Fuse Word Auto-Read Sequencer

This block fetches one 32-bit word from a one-time-programmable fuse array on request. Software programs a cycle window (first and last active cycle) for each of the five array control lines, then writes a request carrying a word address. A cycle counter starts at zero and each line is asserted only while the counter lies inside its own window. The word is captured when the strobe window closes. A sticky finish flag rises when the longest read window ends. Software clears the flag by writing a one to it.

The array contents are modelled as a register image that is loaded with a computed pattern at reset. Program-phase windows are stored and read back, but nothing is ever burned. If software leaves every read window at zero, a built-in window set is used instead, so a request always completes. The register port is a plain valid/ready interface. It is always ready, and read data is returned one cycle after the read is accepted.

Top module: `fuse_autoread_seq`

## Requirements
- R1: After reset the mode register reads 1 (manual mode). Status, data, request and all ten window registers read 0. The array lines rest in standby: csb_n=1, pgen_n=1, load=0, strobe=0, address bus 0.
- R2: Register map (byte offsets). 0x00 holds the mode bit in bit 0. 0x18 is status, finish flag in bit 0. 0x20 is captured data. 0x24 is the request register: bit 0 enable, bit 1 read, bits [25:16] word address. 0x28..0x4C are ten windows in steps of 4: program csb, pgen, load, addr, strobe, then read csb, pgen, load, addr, strobe. Each window holds the first cycle in [31:16] and the last cycle in [15:0]. Windows are read/write over all 32 bits. Unmapped offsets read 0. A read returns its data with reg_rvalid one cycle after it is accepted.
- R3: A write to 0x24 with bits 0 and 1 both set, while the mode bit is 0 and no sequence runs, starts a sequence; the counter is 0 in the cycle after acceptance. Any other write to 0x24 while idle stores the address and read bit but starts nothing, and the enable bit reads 0.
- R4: In sequence cycle k, each read window is active when first <= k <= last. csb_n is low while the csb window is active. load is high while the load window is active. strobe is high while the strobe window is active. The address bus carries the word address while the addr window is active and is 0 otherwise. Windows are sampled when the sequence starts.
- R5: pgen_n stays 1 at all times; reads never enable programming.
- R6: The word is captured in the sequence cycle equal to the strobe window's last cycle. The image word at address a is {a[15:0]^16'hA5C3, ~a[15:0]}. Addresses at or above DEPTH (64) return 0.
- R7: The sequence ends in the cycle equal to the largest last cycle of the five read windows. At that point the finish flag sets, the enable bit clears, and the lines return to standby in the next cycle.
- R8: The finish flag is sticky. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R9: A write to 0x24 while a sequence runs is ignored; the address and the sequence are unchanged.
- R10: If all five read windows are zero, the built-in set is used: csb, pgen and load over cycles 0..11, addr over 2..10, strobe over 5..8.
- R11: Program-phase windows are stored and read back but do not alter a read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | RAW (8) | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted (always 1) |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| fuse_csb_n | output | 1 | Array chip select, active low |
| fuse_pgen_n | output | 1 | Array program enable, active low |
| fuse_load | output | 1 | Array load |
| fuse_addr | output | 10 | Array word address |
| fuse_strobe | output | 1 | Array sense strobe |

## Verification
A counter that starts one cycle late or stops one cycle early shifts every edge of the array lines. That shift shows on the next sequence, in the cycle where the first window opens. A wrong capture point or a wrong image index shows only when the data register is read after the flag rises. A stuck busy state shows as a finish flag that never rises, and as a request address that stops accepting writes. The scoreboard compares all five lines in every cycle of every sequence, and in the first standby cycle after it.

// File: rtl/fuse_autoread_seq.sv
module fuse_autoread_seq #(
  parameter int DEPTH = 64,
  parameter int RAW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_valid,
  input  logic            reg_write,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic            reg_ready,
  output logic            reg_rvalid,
  output logic [31:0]     reg_rdata,
  output logic            fuse_csb_n,
  output logic            fuse_pgen_n,
  output logic            fuse_load,
  output logic [9:0]      fuse_addr,
  output logic            fuse_strobe
);
  localparam int AW   = 10;
  localparam int CW   = 16;
  localparam int NSIG = 5;
  localparam int NWIN = 2 * NSIG;
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [RAW-1:0] A_CTRL = RAW'(8'h00);
  localparam logic [RAW-1:0] A_STAT = RAW'(8'h18);
  localparam logic [RAW-1:0] A_DOUT = RAW'(8'h20);
  localparam logic [RAW-1:0] A_AUTO = RAW'(8'h24);
  localparam logic [RAW-1:0] A_WIN  = RAW'(8'h28);
  localparam int S_CSB = 0, S_LOAD = 2, S_ADDR = 3, S_STRB = 4;

  function automatic logic [31:0] image_word(int unsigned a);
    logic [15:0] a16;
    a16 = a[15:0];
    return {a16 ^ 16'hA5C3, ~a16};
  endfunction

  function automatic logic [CW-1:0] dflt_first(int i);
    return (i == S_ADDR) ? CW'(2) : (i == S_STRB) ? CW'(5) : CW'(0);
  endfunction

  function automatic logic [CW-1:0] dflt_last(int i);
    return (i == S_ADDR) ? CW'(10) : (i == S_STRB) ? CW'(8) : CW'(11);
  endfunction

  logic            user_mode, busy, done, rd_bit;
  logic [AW-1:0]   waddr;
  logic [CW-1:0]   cnt, last_q;
  logic [31:0]     dout_q, rmux, fword;
  logic [31:0]     win_q [NWIN];
  logic [CW-1:0]   first_q [NSIG];
  logic [CW-1:0]   end_q [NSIG];
  logic [31:0]     img [DEPTH];
  logic [CW-1:0]   eff_first [NSIG];
  logic [CW-1:0]   eff_last [NSIG];
  logic [CW-1:0]   last_d;
  logic            rd_zero;
  logic [NSIG-1:0] live;

  wire wr       = reg_valid & reg_write;
  wire rd       = reg_valid & ~reg_write;
  wire wr_auto  = wr && (reg_addr == A_AUTO);
  wire go       = wr_auto && !busy && reg_wdata[0] && reg_wdata[1] && !user_mode;
  wire finish   = busy && (cnt == last_q);
  wire grab     = busy && (cnt == end_q[S_STRB]);
  wire stat_clr = wr && (reg_addr == A_STAT) && reg_wdata[0];

  always_comb begin
    rd_zero = 1'b1;
    for (int i = 0; i < NSIG; i++)
      if (win_q[NSIG+i] != 32'd0) rd_zero = 1'b0;
    last_d = '0;
    for (int i = 0; i < NSIG; i++) begin
      eff_first[i] = rd_zero ? dflt_first(i) : win_q[NSIG+i][31:16];
      eff_last[i]  = rd_zero ? dflt_last(i)  : win_q[NSIG+i][15:0];
      if (eff_last[i] > last_d) last_d = eff_last[i];
    end
  end

  for (genvar g = 0; g < NSIG; g++) begin : g_win
    assign live[g] = busy && (cnt >= first_q[g]) && (cnt <= end_q[g]);
  end

  assign fword       = (32'(waddr) < 32'(DEPTH)) ? img[waddr[IDXW-1:0]] : 32'd0;
  assign fuse_csb_n  = ~live[S_CSB];
  assign fuse_pgen_n = 1'b1;
  assign fuse_load   = live[S_LOAD];
  assign fuse_addr   = live[S_ADDR] ? waddr : '0;
  assign fuse_strobe = live[S_STRB];
  assign reg_ready   = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) win_q[i] <= '0;
    end else begin
      for (int i = 0; i < NWIN; i++)
        if (wr && reg_addr == A_WIN + RAW'(4 * i)) win_q[i] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_mode <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_bit    <= 1'b0;
      waddr     <= '0;
      cnt       <= '0;
      last_q    <= '0;
      dout_q    <= '0;
      for (int i = 0; i < NSIG; i++) begin
        first_q[i] <= '0;
        end_q[i]   <= '0;
      end
      for (int i = 0; i < DEPTH; i++) img[i] <= image_word(i);
    end else begin
      if (wr && reg_addr == A_CTRL) user_mode <= reg_wdata[0];
      if (wr_auto && !busy) begin
        waddr  <= reg_wdata[25:16];
        rd_bit <= reg_wdata[1];
        busy   <= go;
        cnt    <= '0;
        if (go) begin
          last_q <= last_d;
          for (int i = 0; i < NSIG; i++) begin
            first_q[i] <= eff_first[i];
            end_q[i]   <= eff_last[i];
          end
        end
      end else if (busy) begin
        if (finish) busy <= 1'b0;
        else        cnt  <= cnt + 1'b1;
      end
      if (grab) dout_q <= fword;
      if (finish)        done <= 1'b1;
      else if (stat_clr) done <= 1'b0;
    end
  end

  always_comb begin
    rmux = '0;
    if (reg_addr == A_CTRL) rmux = {31'd0, user_mode};
    if (reg_addr == A_STAT) rmux = {31'd0, done};
    if (reg_addr == A_DOUT) rmux = dout_q;
    if (reg_addr == A_AUTO) rmux = {6'd0, waddr, 14'd0, rd_bit, busy};
    for (int i = 0; i < NWIN; i++)
      if (reg_addr == A_WIN + RAW'(4 * i)) rmux = win_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd;
      if (rd) reg_rdata <= rmux;
    end
  end
endmodule

// File: rtl/fuse_autoread_chk.sv
module fuse_autoread_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        user_mode,
  input logic [15:0] cnt,
  input logic [15:0] last_q,
  input logic        wr_auto,
  input logic        stat_clr,
  input logic [9:0]  waddr,
  input logic        csb_n,
  input logic        pgen_n,
  input logic        load,
  input logic        strobe,
  input logic [9:0]  faddr
);
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csb_n && pgen_n && !load && !strobe && faddr == 10'd0)); // R7
  AST_PGEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pgen_n); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= last_q); // R7
  AST_FINISH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_START_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(user_mode) && cnt == 16'd0)); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_auto) |=> $stable(waddr)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stat_clr) |=> done); // R8
endmodule

bind fuse_autoread_seq fuse_autoread_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .user_mode(user_mode),
  .cnt(cnt), .last_q(last_q), .wr_auto(wr_auto), .stat_clr(stat_clr),
  .waddr(waddr), .csb_n(fuse_csb_n), .pgen_n(fuse_pgen_n), .load(fuse_load),
  .strobe(fuse_strobe), .faddr(fuse_addr)
);

// File: tb/sim_fuse_autoread_seq.sv
`timescale 1ns/1ps
module sim_fuse_autoread_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_ready, reg_rvalid;
  logic [31:0] reg_rdata;
  logic fuse_csb_n, fuse_pgen_n, fuse_load, fuse_strobe;
  logic [9:0] fuse_addr;

  always #2.5 clk = ~clk;

  fuse_autoread_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .fuse_csb_n(fuse_csb_n),
    .fuse_pgen_n(fuse_pgen_n), .fuse_load(fuse_load), .fuse_addr(fuse_addr),
    .fuse_strobe(fuse_strobe)
  );

  typedef struct packed {
    logic csb_n, pgen_n, load, strobe;
    logic [9:0] addr;
  } pins_t;

  pins_t  exp_q [$];
  string  tag_q [$];
  int     checks = 0, errors = 0;
  bit     finished = 0;
  int     rfirst [5];
  int     rlast  [5];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(int a);
    if (a >= 64) return 32'd0;
    return {16'(a) ^ 16'hA5C3, ~16'(a)};
  endfunction

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      pins_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, 32'({fuse_csb_n, fuse_pgen_n, fuse_load, fuse_strobe, fuse_addr}), 32'(e));
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    reg_valid = 1'b0;
    @(negedge clk);
    d = reg_rvalid ? reg_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic set_rwin(input int i, input int f, input int l);
    rfirst[i] = f; rlast[i] = l;
    reg_wr(8'h3C + 8'(4 * i), (32'(f) << 16) | 32'(l));
  endtask

  task automatic start_read(input int a);
    int f[5];
    int l[5];
    int last;
    bit zero;
    pins_t p;
    zero = 1;
    for (int i = 0; i < 5; i++) if (rfirst[i] != 0 || rlast[i] != 0) zero = 0;
    for (int i = 0; i < 5; i++) begin
      f[i] = zero ? ((i == 3) ? 2 : (i == 4) ? 5 : 0) : rfirst[i];
      l[i] = zero ? ((i == 3) ? 10 : (i == 4) ? 8 : 11) : rlast[i];
    end
    last = 0;
    for (int i = 0; i < 5; i++) if (l[i] > last) last = l[i];
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h24;
    reg_wdata = (32'(a) << 16) | 32'd3;
    @(posedge clk);
    for (int k = 0; k <= last; k++) begin
      p.csb_n  = !(k >= f[0] && k <= l[0]);
      p.pgen_n = 1'b1;
      p.load   = (k >= f[2] && k <= l[2]);
      p.strobe = (k >= f[4] && k <= l[4]);
      p.addr   = (k >= f[3] && k <= l[3]) ? 10'(a) : 10'd0;
      exp_q.push_back(p);
      tag_q.push_back(zero ? "R10 window" : "R4 window");
    end
    p = '{csb_n: 1'b1, pgen_n: 1'b1, load: 1'b0, strobe: 1'b0, addr: 10'd0};
    exp_q.push_back(p);
    tag_q.push_back("R7 standby");
    #1;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    int tries;
    tries = 0;
    do begin
      reg_rd(8'h18, v);
      tries++;
    end while (v !== 32'd1 && tries < 60);
    check("R7 finish flag", v, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin rfirst[i] = 0; rlast[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    @(negedge clk);
    check("R1 standby pins", 32'({fuse_csb_n, fuse_pgen_n, fuse_load, fuse_strobe, fuse_addr}),
          32'({4'b1100, 10'd0}));
    reg_rd(8'h00, v); check("R1 mode reset", v, 32'd1);
    reg_rd(8'h18, v); check("R1 status reset", v, 32'd0);
    reg_rd(8'h24, v); check("R1 request reset", v, 32'd0);
    reg_rd(8'h4C, v); check("R1 window reset", v, 32'd0);
    reg_rd(8'h10, v); check("R2 unmapped", v, 32'd0);

    reg_wr(8'h24, (32'd5 << 16) | 32'd3);
    repeat (15) @(negedge clk);
    check("R3 manual mode blocks", 32'(fuse_csb_n), 32'd1);
    reg_rd(8'h24, v); check("R3 enable stays 0", v, 32'h0005_0002);
    reg_rd(8'h18, v); check("R3 no finish", v, 32'd0);

    reg_wr(8'h00, 32'd0);
    reg_rd(8'h00, v); check("R2 mode write", v, 32'd0);
    reg_wr(8'h24, (32'd6 << 16) | 32'd1);
    repeat (15) @(negedge clk);
    check("R3 read bit required", 32'(fuse_csb_n), 32'd1);
    reg_rd(8'h24, v); check("R3 no start", v, 32'h0006_0000);

    start_read(5);
    wait_done();
    reg_rd(8'h20, v); check("R6 data word 5", v, word_of(5));
    reg_rd(8'h24, v); check("R7 enable cleared", v, 32'h0005_0002);

    reg_wr(8'h18, 32'd0);
    reg_rd(8'h18, v); check("R8 write 0 keeps flag", v, 32'd1);
    reg_wr(8'h18, 32'd1);
    reg_rd(8'h18, v); check("R8 write 1 clears", v, 32'd0);

    for (int i = 0; i < 5; i++) reg_wr(8'h28 + 8'(4 * i), 32'h0003_0009 + 32'(i));
    reg_rd(8'h34, v); check("R11 program window readback", v, 32'h0003_000C);
    set_rwin(0, 1, 20);
    set_rwin(1, 0, 3);
    set_rwin(2, 2, 18);
    set_rwin(3, 4, 15);
    set_rwin(4, 7, 9);
    reg_rd(8'h4C, v); check("R2 read window readback", v, 32'h0007_0009);

    start_read(63);
    repeat (3) @(negedge clk);
    reg_wr(8'h24, (32'd7 << 16) | 32'd3);
    wait_done();
    reg_rd(8'h20, v); check("R6 data word 63", v, word_of(63));
    reg_rd(8'h24, v); check("R9 busy request ignored", v, 32'h003F_0002);
    reg_wr(8'h18, 32'd1);

    start_read(100);
    wait_done();
    reg_rd(8'h20, v); check("R6 out of range", v, 32'd0);
    reg_wr(8'h18, 32'd1);

    set_rwin(0, 0, 2);
    set_rwin(1, 0, 0);
    set_rwin(2, 0, 0);
    set_rwin(3, 0, 0);
    set_rwin(4, 0, 0);
    start_read(9);
    wait_done();
    reg_rd(8'h20, v); check("R4 short windows data", v, word_of(9));
    check("R5 pgen high", 32'(fuse_pgen_n), 32'd1);

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule